// File: doc/BRIEF.md
# Serial Port Interrupt Event Controller

This block raises the single interrupt request of a serial port that has an extended register set and can also run infrared modes. A six-bit enable register chooses which event sources reach the interrupt line. The sources are the receive and transmit FIFO fill levels, the holding register and the transmitter empty indications, receive timeout, link-status and modem-status events, DMA terminal count, and transmit underrun in consumer-IR mode. The fill-level and empty indications are levels and are used as they arrive. The other sources are single-cycle pulses. Each pulse is held in a pending flag until software clears that flag with a clear strobe.

A CPU register port reaches the enable register in bank 0 at offset 1. One more offset in bank 0 is shared by two registers. A read there returns the event bitmap. A write there passes through to the FIFO control register, which is outside this block. Each source shows up in the event bitmap at the same bit position as its enable bit. The bitmap shows a source whether or not that source is enabled. In consumer-IR mode, position 2 shows link status while receiving and transmit underrun while transmitting.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the event bitmap reads 0x00 with all event inputs low, and irq_o is 0.
- R2: A write to bank 0, offset 1 loads wdata_i[5:0] into the enable register. A read of that offset returns the register with bits 7:6 as zero. A write to any other offset or bank leaves the register unchanged.
- R3: Bitmap bit 0 is set while rx_lvl_i is high, or from the cycle after an rx_tmo_i pulse until that flag is cleared.
- R4: Bitmap bit 1 is set while either tx_lvl_i or thr_empty_i is high.
- R5: A ls_ev_i pulse latches bitmap bit 2, and a ms_ev_i pulse latches bitmap bit 3.
- R6: A dma_tc_i pulse latches bitmap bit 4 only if dma_en_i is high in the same cycle. Otherwise the pulse is ignored.
- R7: Bitmap bit 5 is set while tx_idle_i is high, meaning the transmitter and its FIFO are both empty.
- R8: When cir_mode_i=1, bitmap bit 2 shows the underrun flag (latched by tx_ur_i) while cir_tx_i=1, and the link-status flag while cir_tx_i=0. When cir_mode_i=0, bit 2 always shows the link-status flag and the underrun flag is hidden.
- R9: A read of bank 0, offset 2 returns the event bitmap, which shows sources whether or not they are enabled and has bits 7:6 as zero. A write to that offset pulses fcr_we_o with fcr_data_o=wdata_i and does not change the enable register.
- R10: A high bit k of evt_clr_i clears the latched flags shown at bitmap position k: bit 0 clears timeout, bit 2 clears both link-status and underrun, bit 3 clears modem status, and bit 4 clears DMA. If a set pulse and a clear arrive in the same cycle, the flag stays set.
- R11: irq_o is registered and equals the OR of (bitmap AND enable). It takes on the new value at the clock edge that samples an event, a clear, a mode change or an enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Register port select |
| rd_i | input | 1 | Read cycle |
| wr_i | input | 1 | Write cycle |
| bank_i | input | 2 | Register bank |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational, 0 when not reading) |
| fcr_we_o | output | 1 | Write strobe for the FIFO control register |
| fcr_data_o | output | 8 | Data for the FIFO control register |
| rx_lvl_i | input | 1 | RX FIFO at or above its threshold |
| rx_tmo_i | input | 1 | RX timeout pulse |
| tx_lvl_i | input | 1 | TX FIFO below its threshold |
| thr_empty_i | input | 1 | Holding register empty |
| tx_idle_i | input | 1 | Transmitter and TX FIFO both empty |
| ls_ev_i | input | 1 | Link-status event pulse |
| ms_ev_i | input | 1 | Modem-status event pulse |
| dma_tc_i | input | 1 | DMA terminal-count pulse |
| dma_en_i | input | 1 | DMA enabled |
| tx_ur_i | input | 1 | TX underrun pulse |
| cir_mode_i | input | 1 | Consumer-IR mode select |
| cir_tx_i | input | 1 | Consumer-IR direction, 1 = transmit |
| evt_clr_i | input | 8 | Per-position clear strobes for the latched flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sends a link-status pulse while the block is in consumer-IR transmit mode. A design that does not keep both flags behind the shared position would either raise the interrupt at once or lose the event when the direction flips back to receive. It sends a terminal-count pulse with DMA disabled, which a wrongly gated design would latch. It sends a set and a clear in the same cycle, which a clear-priority design would drop. It masks a level source so that the bitmap must still show the source while the interrupt stays low. It writes the shared offset and checks that a decode fault cannot leak into the enable register. Every interrupt check samples in the cycle right after the triggering edge, so a design with an extra pipeline stage or a combinational output would miss the expected value.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SRC_W  = 6;
  // bitmap / enable positions
  localparam int unsigned B_RX   = 0;
  localparam int unsigned B_TX   = 1;
  localparam int unsigned B_LINK = 2;
  localparam int unsigned B_MDM  = 3;
  localparam int unsigned B_DMA  = 4;
  localparam int unsigned B_IDLE = 5;
  // latched flag slots
  localparam int unsigned FLAG_N = 5;
  localparam int unsigned F_TMO  = 0;
  localparam int unsigned F_LS   = 1;
  localparam int unsigned F_UR   = 2;
  localparam int unsigned F_MS   = 3;
  localparam int unsigned F_DMA  = 4;

  typedef logic [SRC_W-1:0]  src_vec_t;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned BANK_SEL = 0,
  parameter int unsigned IER_OFS  = 1,
  parameter int unsigned EIR_OFS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  src_vec_t          pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fcr_we_o,
  output logic [DATA_W-1:0] fcr_data_o,
  output src_vec_t          ier_q_o,
  output src_vec_t          ier_d_o
);
  localparam logic [ADDR_W-1:0] IER_A = ADDR_W'(IER_OFS);
  localparam logic [ADDR_W-1:0] EIR_A = ADDR_W'(EIR_OFS);
  localparam logic [BANK_W-1:0] BANK_A = BANK_W'(BANK_SEL);

  logic     bank_hit;
  logic     ier_wr;
  src_vec_t ier_q;
  src_vec_t ier_d;

  assign bank_hit = cs_i && (bank_i == BANK_A);
  assign ier_wr   = bank_hit && wr_i && (addr_i == IER_A);
  assign ier_d    = ier_wr ? wdata_i[SRC_W-1:0] : ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ier_q <= '0;
    else         ier_q <= ier_d;
  end

  always_comb begin
    rdata_o = '0;
    if (bank_hit && rd_i) begin
      if (addr_i == IER_A)      rdata_o[SRC_W-1:0] = ier_q;
      else if (addr_i == EIR_A) rdata_o[SRC_W-1:0] = pend_i;
    end
  end

  assign fcr_we_o   = bank_hit && wr_i && (addr_i == EIR_A);
  assign fcr_data_o = wdata_i;
  assign ier_q_o    = ier_q;
  assign ier_d_o    = ier_d;

  assert_ier_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i && addr_i == IER_A) |=> $stable(ier_q));

  assert_fcr_isolated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcr_we_o |=> $stable(ier_q));
endmodule

// File: rtl/uart_irq_evt.sv
module uart_irq_evt #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q_o,
  output logic [N-1:0] flag_d_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set has priority so a coincident event is not lost
    assign flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= flag_d[g];
    end

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);

    assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !set_i[g] |=> !flag_q[g]);

    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !set_i[g] && !clr_i[g] |=> $stable(flag_q[g]));
  end

  assign flag_q_o = flag_q;
  assign flag_d_o = flag_d;
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge
  import uart_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rx_lvl_i,
  input  logic      tx_lvl_i,
  input  logic      thr_empty_i,
  input  logic      tx_idle_i,
  input  logic      cir_mode_i,
  input  logic      cir_tx_i,
  input  flag_vec_t flag_q_i,
  input  flag_vec_t flag_d_i,
  input  src_vec_t  ier_q_i,
  input  src_vec_t  ier_d_i,
  output src_vec_t  pend_o,
  output logic      irq_o
);
  logic     ur_sel;
  src_vec_t pend_nxt;
  logic     irq_q;

  assign ur_sel = cir_mode_i && cir_tx_i;

  function automatic src_vec_t build_map(input flag_vec_t f, input logic rx_l,
                                         input logic tx_l, input logic thr_e,
                                         input logic idle, input logic ur_s);
    src_vec_t m;
    m         = '0;
    m[B_RX]   = rx_l | f[F_TMO];
    m[B_TX]   = tx_l | thr_e;
    m[B_LINK] = ur_s ? f[F_UR] : f[F_LS];
    m[B_MDM]  = f[F_MS];
    m[B_DMA]  = f[F_DMA];
    m[B_IDLE] = idle;
    return m;
  endfunction

  assign pend_o   = build_map(flag_q_i, rx_lvl_i, tx_lvl_i, thr_empty_i, tx_idle_i, ur_sel);
  assign pend_nxt = build_map(flag_d_i, rx_lvl_i, tx_lvl_i, thr_empty_i, tx_idle_i, ur_sel);

  // registered on next-state values: one edge from event to request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_nxt & ier_d_i);
  end

  assign irq_o = irq_q;

  assert_irq_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ier_q_i) |-> !irq_o);

  assert_rx_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_q_i[B_RX] && $past(rx_lvl_i) |-> irq_o);

  assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_q_i[B_IDLE] && $past(tx_idle_i) |-> irq_o);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned BANK_SEL = 0,
  parameter int unsigned IER_OFS  = 1,
  parameter int unsigned EIR_OFS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fcr_we_o,
  output logic [DATA_W-1:0] fcr_data_o,
  input  logic              rx_lvl_i,
  input  logic              rx_tmo_i,
  input  logic              tx_lvl_i,
  input  logic              thr_empty_i,
  input  logic              tx_idle_i,
  input  logic              ls_ev_i,
  input  logic              ms_ev_i,
  input  logic              dma_tc_i,
  input  logic              dma_en_i,
  input  logic              tx_ur_i,
  input  logic              cir_mode_i,
  input  logic              cir_tx_i,
  input  logic [DATA_W-1:0] evt_clr_i,
  output logic              irq_o
);
  src_vec_t  pend;
  src_vec_t  ier_q;
  src_vec_t  ier_d;
  flag_vec_t flag_set;
  flag_vec_t flag_clr;
  flag_vec_t flag_q;
  flag_vec_t flag_d;

  assign flag_set[F_TMO] = rx_tmo_i;
  assign flag_set[F_LS]  = ls_ev_i;
  assign flag_set[F_UR]  = tx_ur_i;
  assign flag_set[F_MS]  = ms_ev_i;
  assign flag_set[F_DMA] = dma_tc_i && dma_en_i;

  // clear strobes follow bitmap positions; position 2 covers both its flags
  assign flag_clr[F_TMO] = evt_clr_i[B_RX];
  assign flag_clr[F_LS]  = evt_clr_i[B_LINK];
  assign flag_clr[F_UR]  = evt_clr_i[B_LINK];
  assign flag_clr[F_MS]  = evt_clr_i[B_MDM];
  assign flag_clr[F_DMA] = evt_clr_i[B_DMA];

  uart_irq_regs #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .BANK_SEL(BANK_SEL),
    .IER_OFS (IER_OFS),
    .EIR_OFS (EIR_OFS)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .bank_i    (bank_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pend_i    (pend),
    .rdata_o   (rdata_o),
    .fcr_we_o  (fcr_we_o),
    .fcr_data_o(fcr_data_o),
    .ier_q_o   (ier_q),
    .ier_d_o   (ier_d)
  );

  uart_irq_evt #(.N(FLAG_N)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flag_q_o(flag_q),
    .flag_d_o(flag_d)
  );

  uart_irq_merge u_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_lvl_i   (rx_lvl_i),
    .tx_lvl_i   (tx_lvl_i),
    .thr_empty_i(thr_empty_i),
    .tx_idle_i  (tx_idle_i),
    .cir_mode_i (cir_mode_i),
    .cir_tx_i   (cir_tx_i),
    .flag_q_i   (flag_q),
    .flag_d_i   (flag_d),
    .ier_q_i    (ier_q),
    .ier_d_i    (ier_d),
    .pend_o     (pend),
    .irq_o      (irq_o)
  );

  assert_dma_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_tc_i && !dma_en_i && !flag_q[F_DMA] |=> !flag_q[F_DMA]);

  assert_ur_hidden_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cir_mode_i && !flag_q[F_LS] |-> !pend[B_LINK]);

  assert_link_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_ev_i && !cir_mode_i |=> pend[B_LINK]);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
  localparam time TCLK = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0;
  logic [1:0] bank = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       fcr_we;
  logic [7:0] fcr_data;
  logic       rx_lvl = 0, rx_tmo = 0, tx_lvl = 0, thr_empty = 0, tx_idle = 0;
  logic       ls_ev = 0, ms_ev = 0, dma_tc = 0, dma_en = 0, tx_ur = 0;
  logic       cir_mode = 0, cir_tx = 0;
  logic [7:0] evt_clr = 0;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // scoreboard: kind 0 irq, 1 rdata, 2 fcr_we, 3 fcr_data
  int         sb_kind[$];
  logic [7:0] sb_exp[$];
  string      sb_req[$];

  always #(TCLK/2) clk = ~clk;

  uart_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .bank_i(bank), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .fcr_we_o(fcr_we), .fcr_data_o(fcr_data),
    .rx_lvl_i(rx_lvl), .rx_tmo_i(rx_tmo), .tx_lvl_i(tx_lvl),
    .thr_empty_i(thr_empty), .tx_idle_i(tx_idle), .ls_ev_i(ls_ev),
    .ms_ev_i(ms_ev), .dma_tc_i(dma_tc), .dma_en_i(dma_en), .tx_ur_i(tx_ur),
    .cir_mode_i(cir_mode), .cir_tx_i(cir_tx), .evt_clr_i(evt_clr),
    .irq_o(irq)
  );

  always @(negedge clk) begin
    while (sb_kind.size() > 0) begin
      int         k;
      logic [7:0] e;
      logic [7:0] a;
      string      r;
      k = sb_kind.pop_front();
      e = sb_exp.pop_front();
      r = sb_req.pop_front();
      case (k)
        0:       a = {7'd0, irq};
        1:       a = rdata;
        2:       a = {7'd0, fcr_we};
        default: a = fcr_data;
      endcase
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", r, k, a, e);
      end
    end
  end

  task automatic push(input int k, input logic [7:0] e, input string r);
    sb_kind.push_back(k);
    sb_exp.push_back(e);
    sb_req.push_back(r);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic exp_irq(input logic e, input string r);
    push(0, {7'd0, e}, r);
    settle();
  endtask

  task automatic reg_wr(input logic [1:0] b, input logic [2:0] a, input logic [7:0] d);
    cs = 1; wr = 1; bank = b; addr = a; wdata = d;
    tick();
    cs = 0; wr = 0; bank = 0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string r);
    cs = 1; rd = 1; bank = 0; addr = a;
    push(1, e, r);
    settle();
    cs = 0; rd = 0;
  endtask

  task automatic pulse_ls();  ls_ev = 1;  tick(); ls_ev = 0;  endtask
  task automatic pulse_ms();  ms_ev = 1;  tick(); ms_ev = 0;  endtask
  task automatic pulse_ur();  tx_ur = 1;  tick(); tx_ur = 0;  endtask
  task automatic pulse_dma(); dma_tc = 1; tick(); dma_tc = 0; endtask
  task automatic clr(input logic [7:0] m); evt_clr = m; tick(); evt_clr = 0; endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    settle();
    exp_irq(0, "R1 irq in reset");
    tick(); rst_n = 1; tick();
    exp_irq(0, "R1 irq after reset");
    exp_rd(3'd1, 8'h00, "R1 ier reset");
    exp_rd(3'd2, 8'h00, "R1 bitmap reset");

    // R2 enable register
    reg_wr(0, 3'd1, 8'hFF);
    exp_rd(3'd1, 8'h3F, "R2 ier reserved bits zero");
    exp_irq(0, "R11 no source pending");
    reg_wr(0, 3'd3, 8'h00);
    exp_rd(3'd1, 8'h3F, "R2 other offset ignored");
    reg_wr(1, 3'd1, 8'h00);
    exp_rd(3'd1, 8'h3F, "R2 other bank ignored");

    // R3 receive
    rx_lvl = 1; tick();
    exp_irq(1, "R3 rx level irq");
    exp_rd(3'd2, 8'h01, "R3 rx level bitmap");
    rx_lvl = 0; tick();
    exp_irq(0, "R3 rx level gone");
    rx_tmo = 1; tick(); rx_tmo = 0;
    exp_irq(1, "R3 timeout irq next edge");
    exp_rd(3'd2, 8'h01, "R3 timeout latched");
    clr(8'h01);
    exp_irq(0, "R10 timeout cleared irq");
    exp_rd(3'd2, 8'h00, "R10 timeout cleared");

    // R4 transmit
    tx_lvl = 1; tick();
    exp_irq(1, "R4 tx level irq");
    exp_rd(3'd2, 8'h02, "R4 tx level bitmap");
    tx_lvl = 0; thr_empty = 1; tick();
    exp_rd(3'd2, 8'h02, "R4 holding empty bitmap");
    thr_empty = 0; tick();
    exp_irq(0, "R4 tx sources gone");

    // R5 link / modem
    pulse_ls();
    exp_rd(3'd2, 8'h04, "R5 link latched");
    pulse_ms();
    exp_rd(3'd2, 8'h0C, "R5 modem latched");
    clr(8'h0C);
    exp_rd(3'd2, 8'h00, "R10 link modem cleared");

    // R6 DMA gate
    dma_en = 0; pulse_dma();
    exp_rd(3'd2, 8'h00, "R6 dma disabled ignored");
    exp_irq(0, "R6 dma disabled no irq");
    dma_en = 1; pulse_dma();
    exp_irq(1, "R6 dma enabled irq");
    exp_rd(3'd2, 8'h10, "R6 dma latched");
    clr(8'h10); dma_en = 0;

    // R7 idle
    tx_idle = 1; tick();
    exp_irq(1, "R7 idle irq");
    exp_rd(3'd2, 8'h20, "R7 idle bitmap");
    tx_idle = 0; tick();

    // R11 masking and enable timing
    reg_wr(0, 3'd1, 8'h00);
    rx_lvl = 1; tick();
    exp_irq(0, "R11 masked source");
    exp_rd(3'd2, 8'h01, "R9 bitmap ignores enable");
    reg_wr(0, 3'd1, 8'h01);
    exp_irq(1, "R11 enable write edge");
    rx_lvl = 0; tick();

    // R8 consumer-IR position 2
    reg_wr(0, 3'd1, 8'h04);
    cir_mode = 1; cir_tx = 1; tick();
    pulse_ls();
    exp_irq(0, "R8 link hidden while transmit");
    exp_rd(3'd2, 8'h00, "R8 link hidden bitmap");
    cir_tx = 0;
    exp_rd(3'd2, 8'h04, "R8 link shown while receive");
    tick();
    exp_irq(1, "R8 link irq receive");
    clr(8'h04);
    cir_tx = 1; pulse_ur();
    exp_irq(1, "R8 underrun irq");
    exp_rd(3'd2, 8'h04, "R8 underrun bitmap");
    clr(8'h04);
    exp_irq(0, "R10 underrun cleared");
    cir_mode = 0; pulse_ur();
    exp_rd(3'd2, 8'h00, "R8 underrun hidden extended");
    clr(8'h04);
    pulse_ls();
    exp_rd(3'd2, 8'h04, "R8 extended ignores direction");
    clr(8'h04); cir_tx = 0;

    // R10 set wins
    ms_ev = 1; evt_clr = 8'h08; tick(); ms_ev = 0; evt_clr = 0;
    exp_rd(3'd2, 8'h08, "R10 set wins over clear");
    clr(8'h08);
    exp_rd(3'd2, 8'h00, "R10 modem cleared");

    // R9 shared offset write
    cs = 1; wr = 1; bank = 0; addr = 3'd2; wdata = 8'hA5;
    push(2, 8'h01, "R9 fcr strobe");
    push(3, 8'hA5, "R9 fcr data");
    settle();
    cs = 0; wr = 0;
    push(2, 8'h00, "R9 fcr strobe idle");
    settle();
    exp_rd(3'd1, 8'h04, "R9 fcr write leaves ier");

    // R9 full bitmap
    rx_lvl = 1; tx_lvl = 1; tx_idle = 1; dma_en = 1;
    ls_ev = 1; ms_ev = 1; dma_tc = 1; tick();
    ls_ev = 0; ms_ev = 0; dma_tc = 0;
    exp_rd(3'd2, 8'h3F, "R9 all sources reserved zero");

    settle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule